// File: doc/BRIEF.md
# Shadowed BCD Time-of-Day and Calendar Registers

This block keeps seconds, minutes, hours, day of week, date, month and two-digit year in binary-coded-decimal counters that run inside the block. Software never reads those running counters directly. It reads a separate user copy, and all seven fields of that copy are overwritten in one cycle after every accepted one-second tick. A control register can freeze the user copy for a consistent read, or freeze it so that software can write a new time. When the write freeze is released, the written values are moved into the running counters.

The block sits on a simple register bus with address, write data, a write strobe, a read strobe and registered read data. The once-per-second timebase arrives as a single-cycle strobe on `tick`. A halt flag in the seconds register stops the counters from taking ticks, and software can set or clear it without first setting the write freeze.

Top module: `bcd_shadow_clock`

## Requirements
- R1: After reset, the user copy and the counters hold 00 seconds, 00 minutes, 00 hours, day of week 01, date 01, month 01 and year 00. The control bits and the halt flag are 0, and the read data is 0.
- R2: The registers sit at these addresses: 0 seconds (bits 6:0, bit 7 is the halt flag), 1 minutes (6:0), 2 hours (5:0), 3 day of week (2:0), 4 date (5:0), 5 month (4:0), 6 year (7:0), 7 control. Bits above a field's width read as 0, and any other address reads 0. Read data appears in the cycle after the read strobe.
- R3: Each accepted tick advances the counters in BCD: seconds wrap 59→00 and carry into minutes, minutes wrap 59→00 and carry into hours, hours wrap 23→00 and carry into the calendar.
- R4: On a day carry, the day of week steps 1..7 and wraps back to 1. The date wraps to 01 after 28, 29, 30 or 31 according to the month, and February has 29 days when the year is divisible by 4 (year 00 included). Month wraps 12→01 and carries into the year, and the year wraps 99→00.
- R5: When the copy is not frozen, all fields of the user copy take the counter values in the cycle after an accepted tick.
- R6: While control bit 6 (read freeze) is 1, the user copy holds its value and the counters keep advancing on ticks. After the bit is cleared, the copy changes only at the next tick's refresh, and it then shows the current count.
- R7: A tick that arrives in the same cycle as the write that sets a freeze bit still completes its refresh of the user copy.
- R8: Control bit 7 (write freeze) freezes the copy, and bus writes to the time registers change only the copy. A control write that changes bit 7 from 1 to 0 loads every field of the copy into the counters. A tick in that same cycle is ignored, and the next refresh comes one tick later.
- R9: A time-register write made while the copy is not frozen is visible in the copy until the next refresh. It does not change the counters.
- R10: Writing 1 to seconds bit 7 sets the halt flag, and it reads back in that bit. While the flag is set, ticks are ignored. Writing 0 clears the flag without the write freeze, and the next tick advances again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per second |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The hardest situations to reach are those that depend on two events landing in the same clock cycle. One is a tick arriving together with the control write that sets a freeze. The other is a tick arriving together with the write that releases the write freeze. The first must still refresh the copy. The second must load the counters and drop the tick. The bench drives the tick and the control write at the same falling edge, so both reach the same rising edge. It then reads the seconds field before the next tick and again after it. Calendar carries are reached by loading 23:59:59 on chosen month ends through the write freeze and sending one tick.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;
  localparam int FIELD_W  = 8;
  localparam int N_FIELDS = 7;

  typedef logic [FIELD_W-1:0] bcd_t;

  // field i sits at bits [i*FIELD_W +: FIELD_W]; index equals bus address
  typedef struct packed {
    bcd_t yr;
    bcd_t mon;
    bcd_t date;
    bcd_t dow;
    bcd_t hr;
    bcd_t min;
    bcd_t sec;
  } tod_t;

  localparam tod_t TOD_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                 hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic bcd_t field_mask(int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // {wrap, next}: BCD increment that folds back to lo once hi is reached
  function automatic logic [8:0] bcd_step(bcd_t v, bcd_t lo, bcd_t hi);
    if (v >= hi)           return {1'b1, lo};
    if (v[3:0] >= 4'd9)    return {1'b0, v[7:4] + 4'd1, 4'h0};
    return {1'b0, v + 8'd1};
  endfunction

  function automatic logic is_leap(bcd_t yr);
    logic [6:0] b;
    b = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return b[1:0] == 2'b00;
  endfunction

  function automatic bcd_t month_end(bcd_t mon, bcd_t yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic tod_t tod_next(tod_t t);
    tod_t n;
    logic [8:0] r;
    n = t;
    r = bcd_step(t.sec, 8'h00, 8'h59);
    n.sec = r[7:0];
    if (r[8]) begin
      r = bcd_step(t.min, 8'h00, 8'h59);
      n.min = r[7:0];
      if (r[8]) begin
        r = bcd_step(t.hr, 8'h00, 8'h23);
        n.hr = r[7:0];
        if (r[8]) begin
          r = bcd_step(t.dow, 8'h01, 8'h07);
          n.dow = r[7:0];
          r = bcd_step(t.date, 8'h01, month_end(t.mon, t.yr));
          n.date = r[7:0];
          if (r[8]) begin
            r = bcd_step(t.mon, 8'h01, 8'h12);
            n.mon = r[7:0];
            if (r[8]) begin
              r = bcd_step(t.yr, 8'h00, 8'h99);
              n.yr = r[7:0];
            end
          end
        end
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/bcdclk_counters.sv
module bcdclk_counters
  import bcdclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load,
  input  tod_t load_val,
  output tod_t now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    now <= TOD_RESET;
    else if (load) now <= load_val;
    else if (step) now <= tod_next(now);
  end
endmodule

// File: rtl/bcdclk_shadow.sv
module bcdclk_shadow
  import bcdclk_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              copy,
  input  tod_t              src,
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  bcd_t              wdata,
  output tod_t              shd
);
  bcd_t fld [N_FIELDS];

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fld[i] <= TOD_RESET[i*FIELD_W +: FIELD_W];
      else if (copy)
        fld[i] <= src[i*FIELD_W +: FIELD_W] & field_mask(i);
      else if (wr && waddr == ADDR_W'(i))
        fld[i] <= wdata & field_mask(i);
    end
    assign shd[i*FIELD_W +: FIELD_W] = fld[i];
  end
endmodule

// File: rtl/bcd_shadow_clock.sv
module bcd_shadow_clock
  import bcdclk_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] SEC_ADDR  = '0;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_FIELDS);
  localparam int WRITE_BIT = 7;
  localparam int READ_BIT  = 6;
  localparam int HALT_BIT  = 7;

  logic ctrl_read, ctrl_write, halt, pend;
  tod_t now, shd;

  // named internal events
  logic ctrl_wr_hit, time_wr, load, tick_acc, frz;
  assign ctrl_wr_hit = bus_we && (bus_addr == CTRL_ADDR);
  assign time_wr     = bus_we && (bus_addr < CTRL_ADDR);
  assign load        = ctrl_wr_hit && ctrl_write && !bus_wdata[WRITE_BIT];
  assign tick_acc    = tick && !halt && !load;
  assign frz         = ctrl_read || ctrl_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_read  <= 1'b0;
      ctrl_write <= 1'b0;
      halt       <= 1'b0;
      pend       <= 1'b0;
    end else begin
      if (ctrl_wr_hit) begin
        ctrl_read  <= bus_wdata[READ_BIT];
        ctrl_write <= bus_wdata[WRITE_BIT];
      end
      if (bus_we && bus_addr == SEC_ADDR) halt <= bus_wdata[HALT_BIT];
      pend <= tick_acc && !frz;
    end
  end

  bcdclk_counters u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tick_acc),
    .load     (load),
    .load_val (shd),
    .now      (now)
  );

  bcdclk_shadow #(.ADDR_W(ADDR_W)) u_shd (
    .clk   (clk),
    .rst_n (rst_n),
    .copy  (pend),
    .src   (now),
    .wr    (time_wr),
    .waddr (bus_addr),
    .wdata (bus_wdata),
    .shd   (shd)
  );

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_FIELDS; i++)
      if (bus_addr == ADDR_W'(i)) rd_mux = shd[i*FIELD_W +: FIELD_W];
    if (bus_addr == SEC_ADDR) rd_mux[HALT_BIT] = halt;
    if (bus_addr == CTRL_ADDR) begin
      rd_mux[WRITE_BIT] = ctrl_write;
      rd_mux[READ_BIT]  = ctrl_read;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/bcdclk_checks.sv
module bcdclk_checks
  import bcdclk_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick_acc,
  input logic load,
  input logic pend,
  input logic frz,
  input logic time_wr,
  input logic halt,
  input tod_t now,
  input tod_t shd
);
  a_r3_tick_moves_count: assert property (@(posedge clk) disable iff (!rst_n)
    tick_acc |=> (now != $past(now)));

  a_r5_copy_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $past(tick_acc));

  a_r6_frozen_copy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !pend && !time_wr) |=> $stable(shd));

  a_r7_pending_copy_lands: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (shd.sec == $past(now.sec) && shd.hr == $past(now.hr)
              && shd.date == $past(now.date)));

  a_r8_release_loads_counters: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (now == $past(shd)));

  a_r10_halt_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !load) |=> $stable(now));
endmodule

bind bcd_shadow_clock bcdclk_checks u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_acc (tick_acc),
  .load     (load),
  .pend     (pend),
  .frz      (frz),
  .time_wr  (time_wr),
  .halt     (halt),
  .now      (now),
  .shd      (shd)
);

// File: tb/sim_bcd_shadow_clock.sv
`timescale 1ns/1ps
module sim_bcd_shadow_clock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  bcd_shadow_clock #(.ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  // ---------------- behavioural reference ----------------
  int         mt [7];            // sec,min,hr,dow,date,mon,yr as plain integers
  logic [7:0] msh [7];           // user copy as raw bytes
  logic [7:0] old_sh [7];
  bit         mhalt, mrd, mwr, mpend, ld, acc, frz0;
  logic [7:0] mrdata, rv;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] msk(int a);
    logic [7:0] w [7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
    return w[a];
  endfunction
  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    mt = '{0, 0, 0, 1, 1, 1, 0};
    for (int i = 0; i < 7; i++) msh[i] = to_bcd(mt[i]);
    mhalt = 0; mrd = 0; mwr = 0; mpend = 0; mrdata = '0;
  endtask

  task automatic model_advance();
    mt[0]++;
    if (mt[0] < 60) return;
    mt[0] = 0; mt[1]++;
    if (mt[1] < 60) return;
    mt[1] = 0; mt[2]++;
    if (mt[2] < 24) return;
    mt[2] = 0;
    mt[3] = mt[3] % 7 + 1;
    mt[4]++;
    if (mt[4] <= days_in(mt[5], mt[6])) return;
    mt[4] = 1; mt[5]++;
    if (mt[5] <= 12) return;
    mt[5] = 1; mt[6] = (mt[6] + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      old_sh = msh;
      ld   = bus_we && bus_addr == 4'd7 && mwr && !bus_wdata[7];
      acc  = tick && !mhalt && !ld;
      frz0 = mrd || mwr;
      if (bus_re) begin
        if (bus_addr < 4'd7) rv = old_sh[bus_addr];
        else if (bus_addr == 4'd7) rv = {mwr, mrd, 6'b0};
        else rv = 8'h00;
        if (bus_addr == 4'd0) rv[7] = mhalt;
        mrdata = rv;
      end
      if (mpend) for (int i = 0; i < 7; i++) msh[i] = to_bcd(mt[i]);
      else if (bus_we && bus_addr < 4'd7) msh[bus_addr] = bus_wdata & msk(int'(bus_addr));
      if (bus_we && bus_addr == 4'd7) begin mwr = bus_wdata[7]; mrd = bus_wdata[6]; end
      if (bus_we && bus_addr == 4'd0) mhalt = bus_wdata[7];
      if (ld) for (int i = 0; i < 7; i++) mt[i] = from_bcd(old_sh[i]);
      else if (acc) model_advance();
      mpend = acc && !frz0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (bus_rdata !== mrdata) begin
        n_bad++;
        $display("FAIL %s model: rdata=%h expected=%h at %0t", cur_req, bus_rdata, mrdata, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); bus_re = 0;
    n_cmp++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: rdata=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    wr(4'd7, 8'h80);
    wr(4'd0, s); wr(4'd1, mi); wr(4'd2, h); wr(4'd3, dw);
    wr(4'd4, dt); wr(4'd5, mo); wr(4'd6, y);
    wr(4'd7, 8'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    cur_req = "R1";
    rd_chk("R1", 4'd0, 8'h00); rd_chk("R1", 4'd2, 8'h00); rd_chk("R1", 4'd3, 8'h01);
    rd_chk("R1", 4'd4, 8'h01); rd_chk("R1", 4'd5, 8'h01); rd_chk("R1", 4'd6, 8'h00);
    rd_chk("R1", 4'd7, 8'h00);
    cur_req = "R2";
    rd_chk("R2", 4'd9, 8'h00);

    cur_req = "R5";
    repeat (3) pulse();
    rd_chk("R5", 4'd0, 8'h03);

    cur_req = "R3";
    set_time(8'h59, 8'h59, 8'h00, 8'h02, 8'h10, 8'h03, 8'h21);
    pulse();
    rd_chk("R3", 4'd2, 8'h01); rd_chk("R3", 4'd1, 8'h00); rd_chk("R3", 4'd0, 8'h00);

    cur_req = "R4";
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24);
    pulse();
    rd_chk("R4", 4'd4, 8'h29); rd_chk("R4", 4'd3, 8'h01); rd_chk("R4", 4'd2, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    pulse();
    rd_chk("R4", 4'd4, 8'h01); rd_chk("R4", 4'd5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h00);
    pulse();
    rd_chk("R4", 4'd4, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h25);
    pulse();
    rd_chk("R4", 4'd4, 8'h01); rd_chk("R4", 4'd5, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99);
    pulse();
    rd_chk("R4", 4'd6, 8'h00); rd_chk("R4", 4'd5, 8'h01);
    rd_chk("R4", 4'd4, 8'h01); rd_chk("R4", 4'd3, 8'h03);

    cur_req = "R6";
    set_time(8'h30, 8'h20, 8'h10, 8'h01, 8'h15, 8'h06, 8'h21);
    pulse();
    rd_chk("R6", 4'd0, 8'h31);
    wr(4'd7, 8'h40);
    repeat (3) pulse();
    rd_chk("R6", 4'd0, 8'h31); rd_chk("R6", 4'd7, 8'h40);
    wr(4'd7, 8'h00);
    rd_chk("R6", 4'd0, 8'h31);
    pulse();
    rd_chk("R6", 4'd0, 8'h35);

    cur_req = "R7";
    @(negedge clk); tick = 1; bus_we = 1; bus_addr = 4'd7; bus_wdata = 8'h40;
    @(negedge clk); tick = 0; bus_we = 0;
    rd_chk("R7", 4'd0, 8'h36);
    pulse();
    rd_chk("R7", 4'd0, 8'h36);
    wr(4'd7, 8'h00);
    pulse();
    rd_chk("R7", 4'd0, 8'h38);

    cur_req = "R9";
    wr(4'd1, 8'h44);
    rd_chk("R9", 4'd1, 8'h44);
    pulse();
    rd_chk("R9", 4'd1, 8'h20); rd_chk("R9", 4'd0, 8'h39);

    cur_req = "R10";
    wr(4'd0, 8'h80);
    rd_chk("R10", 4'd0, 8'h80);
    repeat (2) pulse();
    rd_chk("R10", 4'd0, 8'h80);
    wr(4'd0, 8'h00);
    pulse();
    rd_chk("R10", 4'd0, 8'h40);

    cur_req = "R8";
    wr(4'd7, 8'h80);
    wr(4'd0, 8'h10); wr(4'd1, 8'h11); wr(4'd2, 8'h05);
    rd_chk("R8", 4'd2, 8'h05);
    pulse();
    rd_chk("R8", 4'd0, 8'h10);
    @(negedge clk); tick = 1; bus_we = 1; bus_addr = 4'd7; bus_wdata = 8'h00;
    @(negedge clk); tick = 0; bus_we = 0;
    rd_chk("R8", 4'd0, 8'h10);
    pulse();
    rd_chk("R8", 4'd0, 8'h11); rd_chk("R8", 4'd1, 8'h11); rd_chk("R8", 4'd2, 8'h05);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule